// File: doc/BRIEF.md
# Lagged-Write Pipelined SRAM Front End

This block is a synchronous single-port memory front end built around a small internal array of 72-bit words split into eight 9-bit lanes. Every control input is sampled on the rising clock edge. A command is taken only when the load strobe is low. At that edge the block captures the address, whether the cycle is a read or a write, and the lane write mask. While the load strobe is high, the block repeats the previous cycle type at the next address of a four-beat burst.

Read data leaves through a one-cycle output register. Write data is taken from the data-in bus two edges after its command. A read can therefore follow a write, and a write can follow a read, without an idle cycle on the shared bus. The block gates the data output enable and an echo-clock enable. A bank-level deselect, which happens when either secondary enable does not match its polarity pin, also stops the echo clock. A deselect through the primary enable only turns off the data drivers.

A read whose address matches a write that has been captured but whose data is still in flight takes the incoming bytes merged over the stored word. A read issued one edge after the write therefore returns the new data.

Top module: `lagwrite_sram`

## Requirements
- R1: When `adv_i` is low at an edge, that edge starts a new cycle with `addr_i`, `we_n_i` (high = read, low = write) and `bw_n_i` captured at that edge.
- R2: The block is selected only when `en1_n_i` is low, `en2_i` equals `pol2_i` and `en3_i` equals `pol3_i`. Either polarity setting of a secondary enable works.
- R3: For a read loaded at edge n, `dq_o` holds the stored word and `dq_oe_o` is high from just after edge n+1 until edge n+2.
- R4: For a write loaded at edge n, `dq_i` is sampled at edge n+2. Only lanes whose `bw_n_i` bit was low at edge n are stored, where bit k covers data bits 9k+8 down to 9k.
- R5: A write command with all eight `bw_n_i` bits high stores nothing.
- R6: Each continue edge moves the two low address bits one step through a four-beat sequence while the upper bits stay fixed. With `lin_burst_i` high the step is base+k modulo 4. With it low the step is base XOR k. The fifth access wraps back to the base.
- R7: During a continue, `we_n_i`, `en1_n_i`, `en2_i`, `en3_i` and `addr_i` are ignored. `bw_n_i` is sampled again for each write beat.
- R8: `dq_oe_o` is low from just after edge n+1 when the cycle at edge n is a primary deselect, a bank deselect or a write.
- R9: `cq_oe_o` goes low one edge after a bank deselect (secondary enable mismatch). After a primary deselect, a read or a write it stays high.
- R10: A continue after a deselect or a bank deselect remains that deselect. It neither drives the bus nor stores data.
- R11: A read loaded at the edge after a write to the same address returns the bytes of that write taken from `dq_i`, merged over the stored word.
- R12: After reset, `dq_oe_o` and `cq_oe_o` are low, no write is pending, and continue cycles keep the block bank-deselected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | Word address, sampled on load |
| adv_i | input | 1 | Low = load a new cycle, high = continue the burst |
| we_n_i | input | 1 | Cycle type on load: high = read, low = write |
| bw_n_i | input | LANES | Active-low lane write mask |
| en1_n_i | input | 1 | Active-low primary enable |
| en2_i | input | 1 | Secondary enable, active level set by pol2_i |
| en3_i | input | 1 | Secondary enable, active level set by pol3_i |
| pol2_i | input | 1 | Static active level of en2_i |
| pol3_i | input | 1 | Static active level of en3_i |
| lin_burst_i | input | 1 | Static burst order: high = linear, low = interleaved |
| dq_i | input | LANES*LANE_W | Incoming write data |
| dq_o | output | LANES*LANE_W | Registered read data |
| dq_oe_o | output | 1 | Data bus drive enable |
| cq_oe_o | output | 1 | Echo-clock drive enable |

## Verification
The hardest case to reach from the ports is a read that overlaps a write whose data is still on its way. The two commands must be issued on consecutive edges to the same word, and the write data must be placed on `dq_i` in the very cycle in which the read result is being registered. The bench issues a partial-lane write, then on the next edge a read of the same address. It then drives the new data exactly two edges after the write. A second read at the data edge checks that the array commit and the forwarded value agree. The continue cycles in this bench also carry deliberately conflicting values on the ignored inputs.

// File: rtl/lw_pkg.sv
// Shared cycle encoding and burst address helper for the lagged-write SRAM.
// Assumes bursts are four beats long and step the two low address bits.
package lw_pkg;

    typedef enum logic [1:0] {
        CYC_BANKOFF = 2'd0,
        CYC_IDLE    = 2'd1,
        CYC_READ    = 2'd2,
        CYC_WRITE   = 2'd3
    } cyc_e;

    // Low two address bits for burst beat `step` from `base`.
    function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                            input logic [1:0] step,
                                            input logic       linear);
        return linear ? 2'(base + step) : (base ^ step);
    endfunction

endpackage

// File: rtl/lw_cmd.sv
// Command decoder and burst address generator.
// Holds the active cycle type, the loaded base address, the burst step and the
// lane mask of the current beat. Assumes ADDR_W >= 2.
module lw_cmd #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                adv_i,
    input  logic                we_n_i,
    input  logic [LANES-1:0]    bw_n_i,
    input  logic                en1_n_i,
    input  logic                en2_i,
    input  logic                en3_i,
    input  logic                pol2_i,
    input  logic                pol3_i,
    input  logic                lin_i,
    output lw_pkg::cyc_e        cyc_o,
    output logic [ADDR_W-1:0]   eff_addr_o,
    output logic [LANES-1:0]    bw_n_o
);
    import lw_pkg::*;

    cyc_e               cyc_q;
    cyc_e               load_cyc;
    logic [ADDR_W-1:0]  base_q;
    logic [1:0]         step_q;
    logic [LANES-1:0]   bw_q;
    logic               bank_ok;

    // Classify a load edge from the enables and the read/write strobe.
    always_comb begin
        bank_ok = (en2_i == pol2_i) && (en3_i == pol3_i);
        if (!bank_ok)
            load_cyc = CYC_BANKOFF;
        else if (en1_n_i)
            load_cyc = CYC_IDLE;
        else if (we_n_i)
            load_cyc = CYC_READ;
        else
            load_cyc = CYC_WRITE;
    end

    // Capture a new cycle on load, or step the burst on continue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= CYC_BANKOFF;
            base_q <= '0;
            step_q <= '0;
            bw_q   <= '1;
        end else if (!adv_i) begin
            cyc_q  <= load_cyc;
            base_q <= addr_i;
            step_q <= '0;
            bw_q   <= bw_n_i;
        end else if (cyc_q == CYC_READ || cyc_q == CYC_WRITE) begin
            step_q <= step_q + 2'd1;
            bw_q   <= bw_n_i;
        end
    end

    assign cyc_o      = cyc_q;
    assign eff_addr_o = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], step_q, lin_i)};
    assign bw_n_o     = bw_q;

endmodule

// File: rtl/lw_wstage.sv
// Write-data stage: remembers a write whose data arrives on the next edge,
// and merges that incoming data into a read of the same word.
// Assumes the data bus carries the write data in the cycle before the commit edge.
module lw_wstage #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 8,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  lw_pkg::cyc_e              cyc_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [LANES-1:0]          bw_n_i,
    input  logic [LANES*LANE_W-1:0]   dq_i,
    input  logic [LANES*LANE_W-1:0]   arr_rdata_i,
    output logic                      wr_en_o,
    output logic [ADDR_W-1:0]         wr_addr_o,
    output logic [LANES-1:0]          wr_mask_o,
    output logic [LANES*LANE_W-1:0]   wr_data_o,
    output logic [LANES*LANE_W-1:0]   fwd_data_o
);
    import lw_pkg::*;

    logic               pend_v;
    logic [ADDR_W-1:0]  pend_addr;
    logic [LANES-1:0]   pend_mask;
    logic               hit;

    // Hold the write beat that will take its data at the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_addr <= '0;
            pend_mask <= '0;
        end else begin
            pend_v    <= (cyc_i == CYC_WRITE);
            pend_addr <= addr_i;
            pend_mask <= ~bw_n_i;
        end
    end

    assign hit       = pend_v && (pend_addr == addr_i);
    assign wr_en_o   = pend_v;
    assign wr_addr_o = pend_addr;
    assign wr_mask_o = pend_mask;
    assign wr_data_o = dq_i;

    // Per lane, choose the in-flight byte over the stored one on a hit.
    for (genvar k = 0; k < LANES; k++) begin : g_fwd
        assign fwd_data_o[k*LANE_W +: LANE_W] =
            (hit && pend_mask[k]) ? dq_i[k*LANE_W +: LANE_W]
                                  : arr_rdata_i[k*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/lw_store.sv
// Storage array: one memory per lane with a masked write port and an
// asynchronous read port. Contents are not reset.
module lw_store #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 8,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      we_i,
    input  logic [ADDR_W-1:0]         waddr_i,
    input  logic [LANES-1:0]          wmask_i,
    input  logic [LANES*LANE_W-1:0]   wdata_i,
    input  logic [ADDR_W-1:0]         raddr_i,
    output logic [LANES*LANE_W-1:0]   rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Commit this lane when the write is enabled and the lane is unmasked.
        always_ff @(posedge clk) begin
            if (we_i && wmask_i[k])
                mem[waddr_i] <= wdata_i[k*LANE_W +: LANE_W];
        end

        assign rdata_o[k*LANE_W +: LANE_W] = mem[raddr_i];
    end

endmodule

// File: rtl/lw_outstage.sv
// Output register stage: latches read data and derives the data and
// echo-clock drive enables one edge after the cycle that causes them.
module lw_outstage #(
    parameter int DATA_W = 72
) (
    input  logic                clk,
    input  logic                rst_n,
    input  lw_pkg::cyc_e        cyc_i,
    input  logic [DATA_W-1:0]   rdata_i,
    output logic [DATA_W-1:0]   dq_o,
    output logic                dq_oe_o,
    output logic                cq_oe_o
);
    import lw_pkg::*;

    // Register read data and the two drive enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_o    <= '0;
            dq_oe_o <= 1'b0;
            cq_oe_o <= 1'b0;
        end else begin
            if (cyc_i == CYC_READ)
                dq_o <= rdata_i;
            dq_oe_o <= (cyc_i == CYC_READ);
            cq_oe_o <= (cyc_i != CYC_BANKOFF);
        end
    end

endmodule

// File: rtl/lagwrite_sram.sv
// Lagged-write pipelined SRAM front end (top level).
// Reads return data one edge after the command; write data follows its
// command by two edges. Assumes pol2_i, pol3_i and lin_burst_i are static.
module lagwrite_sram #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 8,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic                      adv_i,
    input  logic                      we_n_i,
    input  logic [LANES-1:0]          bw_n_i,
    input  logic                      en1_n_i,
    input  logic                      en2_i,
    input  logic                      en3_i,
    input  logic                      pol2_i,
    input  logic                      pol3_i,
    input  logic                      lin_burst_i,
    input  logic [LANES*LANE_W-1:0]   dq_i,
    output logic [LANES*LANE_W-1:0]   dq_o,
    output logic                      dq_oe_o,
    output logic                      cq_oe_o
);
    localparam int DATA_W = LANES * LANE_W;

    lw_pkg::cyc_e        cyc;
    logic [ADDR_W-1:0]   eff_addr;
    logic [LANES-1:0]    cur_bw_n;
    logic                wr_en;
    logic [ADDR_W-1:0]   wr_addr;
    logic [LANES-1:0]    wr_mask;
    logic [DATA_W-1:0]   wr_data;
    logic [DATA_W-1:0]   arr_rdata;
    logic [DATA_W-1:0]   fwd_data;

    lw_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .adv_i      (adv_i),
        .we_n_i     (we_n_i),
        .bw_n_i     (bw_n_i),
        .en1_n_i    (en1_n_i),
        .en2_i      (en2_i),
        .en3_i      (en3_i),
        .pol2_i     (pol2_i),
        .pol3_i     (pol3_i),
        .lin_i      (lin_burst_i),
        .cyc_o      (cyc),
        .eff_addr_o (eff_addr),
        .bw_n_o     (cur_bw_n)
    );

    lw_wstage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wstage (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_i       (cyc),
        .addr_i      (eff_addr),
        .bw_n_i      (cur_bw_n),
        .dq_i        (dq_i),
        .arr_rdata_i (arr_rdata),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .wr_mask_o   (wr_mask),
        .wr_data_o   (wr_data),
        .fwd_data_o  (fwd_data)
    );

    lw_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk     (clk),
        .we_i    (wr_en),
        .waddr_i (wr_addr),
        .wmask_i (wr_mask),
        .wdata_i (wr_data),
        .raddr_i (eff_addr),
        .rdata_o (arr_rdata)
    );

    lw_outstage #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_i   (cyc),
        .rdata_i (fwd_data),
        .dq_o    (dq_o),
        .dq_oe_o (dq_oe_o),
        .cq_oe_o (cq_oe_o)
    );

endmodule

// File: rtl/lagwrite_sram_chk.sv
// Port-level timing checker for lagwrite_sram, attached with bind.
// Relates load commands at the inputs to the drive enables two edges later.
module lagwrite_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic adv_i,
    input logic we_n_i,
    input logic en1_n_i,
    input logic en2_i,
    input logic en3_i,
    input logic pol2_i,
    input logic pol3_i,
    input logic dq_oe_o,
    input logic cq_oe_o
);
    logic bank_ok;
    assign bank_ok = (en2_i == pol2_i) && (en3_i == pol3_i);

    assert_read_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && bank_ok && !en1_n_i && we_n_i) |=> ##1 dq_oe_o);

    assert_write_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && bank_ok && !en1_n_i && !we_n_i) |=> ##1 !dq_oe_o);

    assert_idle_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && bank_ok && en1_n_i) |=> ##1 !dq_oe_o);

    assert_idle_keeps_echo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && bank_ok && en1_n_i) |=> ##1 cq_oe_o);

    assert_bank_off_stops_echo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !bank_ok) |=> ##1 (!cq_oe_o && !dq_oe_o));

endmodule

bind lagwrite_sram lagwrite_sram_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (adv_i),
    .we_n_i  (we_n_i),
    .en1_n_i (en1_n_i),
    .en2_i   (en2_i),
    .en3_i   (en3_i),
    .pol2_i  (pol2_i),
    .pol3_i  (pol3_i),
    .dq_oe_o (dq_oe_o),
    .cq_oe_o (cq_oe_o)
);

// File: tb/tb_lagwrite_sram.sv
// Directed bench for lagwrite_sram: one task per scenario, each checking itself.
module tb_lagwrite_sram;
    localparam int AW = 8;
    localparam int NL = 8;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_i;
    logic          adv_i, we_n_i, en1_n_i, en2_i, en3_i, pol2_i, pol3_i, lin_burst_i;
    logic [NL-1:0] bw_n_i;
    logic [DW-1:0] dq_i, dq_o;
    logic          dq_oe_o, cq_oe_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lagwrite_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .adv_i(adv_i), .we_n_i(we_n_i),
        .bw_n_i(bw_n_i), .en1_n_i(en1_n_i), .en2_i(en2_i), .en3_i(en3_i),
        .pol2_i(pol2_i), .pol3_i(pol3_i), .lin_burst_i(lin_burst_i), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o), .cq_oe_o(cq_oe_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        logic [DW-1:0] r;
        for (int k = 0; k < NL; k++)
            r[k*LW +: LW] = 9'((a * 7 + salt * 13 + k * 29 + 5) % 512);
        return r;
    endfunction

    // New lanes (mask bit low) from nw, the rest from old.
    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [DW-1:0] nw,
                                            input logic [NL-1:0] bw_n);
        logic [DW-1:0] r;
        for (int k = 0; k < NL; k++)
            r[k*LW +: LW] = bw_n[k] ? old[k*LW +: LW] : nw[k*LW +: LW];
        return r;
    endfunction

    // Drive one edge's inputs, let the edge pass, return at the falling edge.
    task automatic issue(input logic adv, input logic wen, input logic e1n,
                         input logic bank, input logic [AW-1:0] a, input logic [NL-1:0] bw);
        adv_i   = adv;
        we_n_i  = wen;
        en1_n_i = e1n;
        en2_i   = bank ? pol2_i : ~pol2_i;
        en3_i   = pol3_i;
        addr_i  = a;
        bw_n_i  = bw;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a);  issue(1'b0, 1'b1, 1'b0, 1'b1, a, '1); endtask
    task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] bw); issue(1'b0, 1'b0, 1'b0, 1'b1, a, bw); endtask
    task automatic nop();  issue(1'b0, 1'b1, 1'b1, 1'b1, '0, '1); endtask
    task automatic bdes(); issue(1'b0, 1'b1, 1'b0, 1'b0, '0, '1); endtask
    // Continue with conflicting values on every ignored input (R7).
    task automatic cont(input logic [NL-1:0] bw); issue(1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, bw); endtask

    task automatic t_reset();
        rst_n = 1'b0;
        nop(); nop();
        rst_n = 1'b1;
        chk("R12", "dq_oe after reset", {71'b0, dq_oe_o}, '0);
        chk("R12", "cq_oe after reset", {71'b0, cq_oe_o}, '0);
        dq_i = pat(1, 1);
        cont('0); cont('0);
        chk("R12", "dq_oe continue after reset", {71'b0, dq_oe_o}, '0);
        chk("R12", "cq_oe continue after reset", {71'b0, cq_oe_o}, '0);
    endtask

    task automatic t_write_read();
        wr(8'h10, '0);
        wr(8'h11, '0);
        dq_i = pat(16, 0); nop();
        dq_i = pat(17, 0); nop();
        rd(8'h10);
        rd(8'h11);
        chk("R1", "read 0x10 data", dq_o, pat(16, 0));
        chk("R3", "dq_oe on read", {71'b0, dq_oe_o}, 72'd1);
        nop();
        chk("R4", "read 0x11 data", dq_o, pat(17, 0));
        nop();
        chk("R8", "dq_oe after deselect", {71'b0, dq_oe_o}, '0);
        rd(8'h10);
        wr(8'h12, '0);
        chk("R3", "dq_oe read before write", {71'b0, dq_oe_o}, 72'd1);
        nop();
        chk("R8", "dq_oe after write", {71'b0, dq_oe_o}, '0);
        dq_i = pat(18, 0); nop();
    endtask

    task automatic t_mask();
        logic [DW-1:0] exp_w;
        wr(8'h20, '0); nop();
        dq_i = pat(32, 1); nop();
        wr(8'h20, 8'b1111_1010); nop();
        dq_i = pat(32, 2); nop();
        exp_w = merge(pat(32, 1), pat(32, 2), 8'b1111_1010);
        rd(8'h20); nop();
        chk("R4", "lane-masked write", dq_o, exp_w);
        wr(8'h20, '1); nop();
        dq_i = pat(32, 3); nop();
        rd(8'h20); nop();
        chk("R5", "write abort keeps word", dq_o, exp_w);
    endtask

    task automatic t_burst();
        lin_burst_i = 1'b1;
        wr(8'h31, '0);
        cont('0);
        dq_i = pat(8'h31, 4); cont('0);
        dq_i = pat(8'h32, 4); cont('0);
        dq_i = pat(8'h33, 4); nop();
        dq_i = pat(8'h30, 4); nop();
        lin_burst_i = 1'b0;
        rd(8'h31);
        cont('1); chk("R6", "interleaved beat0", dq_o, pat(8'h31, 4));
        cont('1); chk("R6", "interleaved beat1", dq_o, pat(8'h30, 4));
        cont('1); chk("R6", "interleaved beat2", dq_o, pat(8'h33, 4));
        cont('1); chk("R7", "interleaved beat3 ignored inputs", dq_o, pat(8'h32, 4));
        nop();    chk("R6", "wrap to base", dq_o, pat(8'h31, 4));
        chk("R7", "read kept through continues", {71'b0, dq_oe_o}, 72'd1);
        lin_burst_i = 1'b1;
        rd(8'h32);
        cont('1); chk("R6", "linear beat0", dq_o, pat(8'h32, 4));
        cont('1); chk("R6", "linear beat1", dq_o, pat(8'h33, 4));
        cont('1); chk("R6", "linear beat2", dq_o, pat(8'h30, 4));
        nop();    chk("R6", "linear beat3", dq_o, pat(8'h31, 4));
        nop();
    endtask

    task automatic t_forward();
        logic [DW-1:0] exp_w;
        wr(8'h40, '0); nop();
        dq_i = pat(64, 5); nop();
        wr(8'h40, 8'b1111_1101);
        rd(8'h40);
        dq_i = pat(64, 6);
        rd(8'h40);
        exp_w = merge(pat(64, 5), pat(64, 6), 8'b1111_1101);
        chk("R11", "read merges in-flight write", dq_o, exp_w);
        nop();
        chk("R11", "read at commit edge", dq_o, exp_w);
        nop();
    endtask

    task automatic t_select();
        logic [DW-1:0] exp_w;
        exp_w = merge(pat(64, 5), pat(64, 6), 8'b1111_1101);
        rd(8'h40);
        bdes();
        chk("R9", "cq_oe during read", {71'b0, cq_oe_o}, 72'd1);
        cont('1);
        chk("R9", "cq_oe after bank deselect", {71'b0, cq_oe_o}, '0);
        chk("R8", "dq_oe after bank deselect", {71'b0, dq_oe_o}, '0);
        cont('1);
        chk("R10", "bank deselect continue", {71'b0, cq_oe_o}, '0);
        nop();
        chk("R10", "still bank deselected", {71'b0, cq_oe_o}, '0);
        nop();
        chk("R9", "cq_oe on primary deselect", {71'b0, cq_oe_o}, 72'd1);
        chk("R8", "dq_oe on primary deselect", {71'b0, dq_oe_o}, '0);
        dq_i = pat(64, 7);
        issue(1'b1, 1'b0, 1'b0, 1'b1, 8'h40, '0);
        issue(1'b1, 1'b0, 1'b0, 1'b1, 8'h40, '0);
        nop();
        chk("R10", "continue after deselect no drive", {71'b0, dq_oe_o}, '0);
        nop();
        rd(8'h40); nop();
        chk("R10", "continue after deselect no store", dq_o, exp_w);
        pol2_i = 1'b0; pol3_i = 1'b1;
        nop();
        rd(8'h40); nop();
        chk("R2", "inverted polarity selects", dq_o, exp_w);
        chk("R2", "inverted polarity drives", {71'b0, dq_oe_o}, 72'd1);
        bdes(); nop();
        chk("R2", "mismatched enable deselects bank", {71'b0, cq_oe_o}, '0);
        pol2_i = 1'b1; pol3_i = 1'b0;
        nop(); nop();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; addr_i = '0; adv_i = 1'b0; we_n_i = 1'b1; bw_n_i = '1;
        en1_n_i = 1'b1; pol2_i = 1'b1; pol3_i = 1'b0; en2_i = 1'b1; en3_i = 1'b0;
        lin_burst_i = 1'b1; dq_i = '0;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_mask();
        t_burst();
        t_forward();
        t_select();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule